// File: doc/BRIEF.md
# Frame-Synchronous Contention Arbiter

This block decides which of several upstream senders may use a shared channel into one receiver. Time is cut into fixed-length frames. Each frame opens with a contention interval and closes with a data interval. Every sender that has data and still holds downstream credit raises a request during the contention interval and presents a contention number. The receiver side compares all the presented numbers in one step on the last contention cycle. It then gives the largest number a grant, which stays open for the whole data interval of that same frame.

The sender-side number generators sit inside the block, one per sender. Each number has two parts. The top bit is a priority flag, raised for the round after that sender's node has received a packet. The bits below it are a random field taken from a per-sender LFSR. A sender with no credit left stays silent. A grant spends one credit. Credit comes back only when the downstream node signals that it has released or consumed an earlier packet.

The frame length, the contention length, the number width and the sender count are parameters, and elaboration checks reject settings that cannot work.

Top module: `contention_arbiter`

## Requirements
- R1: A frame counter restarts at zero on the first cycle after reset and at every frame end. `cont_phase` is 1 for the first CONT_LEN cycles of each FRAME_LEN-cycle frame, and `data_phase` is 1 for the rest. The two are never equal.
- R2: `req_out[i]` is 1 exactly when `cont_phase` is 1, `has_data[i]` is 1 and sender i holds at least one credit.
- R3: Requests are compared only on the last contention cycle. The result is registered, so `grant` shows it on every data cycle of that same frame and is all zeros on every contention cycle.
- R4: `grant` is one-hot on the requester with the largest contention number, and lower index wins on equal numbers. When no request is present on the deciding cycle, `grant` stays all zeros for that frame.
- R5: Bit K-1 of each sender's number is its priority flag. A `pkt_rcvd[i]` pulse sets the flag. Any deciding cycle without such a pulse clears it, so a prioritized number beats every unprioritized one in the next round.
- R6: Each sender starts with CREDITS credits. Winning an arbitration removes one credit and a `credit_ret[i]` pulse adds one, and when both happen in the same cycle the count does not change. The count never goes above CREDITS, and a sender with zero credits does not request.
- R7: Bits K-2..0 of sender i's number form a Fibonacci LFSR seeded with i+1. It steps once per frame, on the deciding cycle: the register shifts up by one and the feedback bit enters at bit 0. For K=5 the feedback is bit 3 XOR bit 2.
- R8: While in reset, `grant` is zero, every priority flag is zero, every credit count is full, and sender i's number reads i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| has_data | input | N | Sender i has a packet waiting |
| pkt_rcvd | input | N | Pulse: sender i's node just received a packet |
| credit_ret | input | N | Pulse: downstream freed one buffer for sender i |
| cont_phase | output | 1 | Current cycle is in the contention interval |
| data_phase | output | 1 | Current cycle is in the data interval |
| req_out | output | N | Sender i is contending this cycle |
| cont_num | output | N*K | Contention numbers, sender i at bits i*K+K-1..i*K |
| grant | output | N | One-hot data-interval grant |

## Verification
The credit assertions assume that `credit_ret` is never pulsed for a sender whose count is already full, because the block trusts the downstream node's return signal. The stimulus keeps a shadow credit count per sender and only returns a credit when that count is below CREDITS. Priority pulses, data presence and credit returns are otherwise free, and that includes pulses on the deciding cycle itself. The stimulus also drains all credits with constant demand, so that frames with no request at all are covered.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // Feedback tap mask for a maximal-length Fibonacci LFSR of width w.
   function automatic logic [7:0] lfsr_taps(input int unsigned w);
      case (w)
         3:       lfsr_taps = 8'h06;
         4:       lfsr_taps = 8'h0C;
         5:       lfsr_taps = 8'h14;
         6:       lfsr_taps = 8'h30;
         7:       lfsr_taps = 8'h60;
         default: lfsr_taps = 8'hB8;
      endcase
   endfunction

   localparam int unsigned MIN_NUM_W = 4;
   localparam int unsigned MAX_NUM_W = 9;

endpackage

// File: rtl/arb_frame_timer.sv
module arb_frame_timer #(
   parameter int unsigned FRAME_LEN = 8,
   parameter int unsigned CONT_LEN  = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic cont_phase,
   output logic data_phase,
   output logic decide,
   output logic frame_last
);
   localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (frame_last) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   always_comb begin
      frame_last = (cnt == CW'(FRAME_LEN - 1));
      cont_phase = (cnt <  CW'(CONT_LEN));
      decide     = (cnt == CW'(CONT_LEN - 1));
      data_phase = !cont_phase;
   end

   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      cont_phase != data_phase);                                        // R1
   AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |=> cont_phase);                                       // R1
   AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> data_phase);                                           // R1

endmodule

// File: rtl/arb_cn_gen.sv
module arb_cn_gen #(
   parameter int unsigned K       = 5,
   parameter int unsigned CREDITS = 2,
   parameter int unsigned SEED    = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cont_phase,
   input  logic         decide,
   input  logic         has_data,
   input  logic         pkt_rcvd,
   input  logic         credit_ret,
   input  logic         won,
   output logic         req,
   output logic [K-1:0] num
);
   localparam int unsigned RW  = K - 1;
   localparam int unsigned CRW = $clog2(CREDITS + 1);
   localparam logic [RW-1:0] TAPS   = RW'(arb_pkg::lfsr_taps(RW));
   localparam logic [RW-1:0] SEED_V = RW'(SEED);

   logic [RW-1:0]  lfsr;
   logic           prio;
   logic [CRW-1:0] credit;
   logic           fb;

   assign fb = ^(lfsr & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n)      lfsr <= SEED_V;
      else if (decide) lfsr <= {lfsr[RW-2:0], fb};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        prio <= 1'b0;
      else if (pkt_rcvd) prio <= 1'b1;
      else if (decide)   prio <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credit <= CRW'(CREDITS);
      end else begin
         case ({won, credit_ret})
            2'b10:   credit <= credit - 1'b1;
            2'b01:   credit <= credit + 1'b1;
            default: credit <= credit;
         endcase
      end
   end

   assign num = {prio, lfsr};
   assign req = cont_phase & has_data & (credit != '0);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      credit <= CRW'(CREDITS));                                         // R6
   AST_DRY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (credit == '0) |-> !req);                                         // R6
   AST_SPEND_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (won && !credit_ret) |=> (credit == $past(credit) - 1'b1));       // R6
   AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);                                                      // R7
   AST_LFSR_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !decide |=> $stable(lfsr));                                       // R7
   AST_PRIO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !pkt_rcvd) |=> !prio);                                 // R5
   AST_PRIO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_rcvd |=> prio);                                               // R5

endmodule

// File: rtl/arb_max_sel.sv
module arb_max_sel #(
   parameter int unsigned N = 4,
   parameter int unsigned K = 5
) (
   input  logic [N-1:0]   req,
   input  logic [N*K-1:0] nums,
   output logic [N-1:0]   pick
);
   logic         found;
   logic [K-1:0] best;

   // Strict comparison keeps the earlier (lower-index) entry on equal numbers.
   always_comb begin
      pick  = '0;
      found = 1'b0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!found || (nums[i*K +: K] > best))) begin
            pick    = '0;
            pick[i] = 1'b1;
            best    = nums[i*K +: K];
            found   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/contention_arbiter.sv
module contention_arbiter #(
   parameter int unsigned N         = 4,
   parameter int unsigned K         = 5,
   parameter int unsigned FRAME_LEN = 8,
   parameter int unsigned CONT_LEN  = 3,
   parameter int unsigned CREDITS   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   has_data,
   input  logic [N-1:0]   pkt_rcvd,
   input  logic [N-1:0]   credit_ret,
   output logic           cont_phase,
   output logic           data_phase,
   output logic [N-1:0]   req_out,
   output logic [N*K-1:0] cont_num,
   output logic [N-1:0]   grant
);
   localparam int unsigned RW = K - 1;

   initial begin : elab_checks
      assert (K >= arb_pkg::MIN_NUM_W && K <= arb_pkg::MAX_NUM_W)
         else $error("contention number width out of range");
      assert (N >= 1 && N < (1 << RW))
         else $error("sender count needs distinct nonzero seeds");
      assert (CONT_LEN >= 1 && CONT_LEN < FRAME_LEN)
         else $error("contention interval must leave a data interval");
      assert (CREDITS >= 1)
         else $error("at least one credit required");
   end

   logic         decide;
   logic         frame_last;
   logic [N-1:0] pick;

   arb_frame_timer #(.FRAME_LEN(FRAME_LEN), .CONT_LEN(CONT_LEN)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cont_phase (cont_phase),
      .data_phase (data_phase),
      .decide     (decide),
      .frame_last (frame_last)
   );

   for (genvar g = 0; g < N; g++) begin : g_sender
      arb_cn_gen #(.K(K), .CREDITS(CREDITS), .SEED(g + 1)) i_gen (
         .clk        (clk),
         .rst_n      (rst_n),
         .cont_phase (cont_phase),
         .decide     (decide),
         .has_data   (has_data[g]),
         .pkt_rcvd   (pkt_rcvd[g]),
         .credit_ret (credit_ret[g]),
         .won        (decide & pick[g]),
         .req        (req_out[g]),
         .num        (cont_num[g*K +: K])
      );
   end

   arb_max_sel #(.N(N), .K(K)) i_sel (
      .req  (req_out),
      .nums (cont_num),
      .pick (pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          grant <= '0;
      else if (decide)     grant <= pick;
      else if (frame_last) grant <= '0;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));                                                 // R4
   AST_GRANT_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> data_phase);                                         // R3
   AST_GRANT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && (|req_out)) |=> ($countones(grant) == 1));             // R3
   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !(|req_out)) |=> (grant == '0));                       // R4
   AST_WINNER_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
      decide |=> ((grant & ~$past(req_out)) == '0));                    // R4
   AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (data_phase && !frame_last) |=> $stable(grant));                  // R3

endmodule

// File: tb/test_contention_arbiter.sv
module test_contention_arbiter;
   localparam int N = 4, K = 5, FL = 8, CL = 3, CR = 2;
   localparam int CYCLES = 3200;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   has_data = '0, pkt_rcvd = '0, credit_ret = '0;
   logic           cont_phase, data_phase;
   logic [N-1:0]   req_out, grant;
   logic [N*K-1:0] cont_num;

   always #5 clk = ~clk;

   contention_arbiter #(.N(N), .K(K), .FRAME_LEN(FL), .CONT_LEN(CL), .CREDITS(CR)) i_contention_arbiter (
      .clk(clk), .rst_n(rst_n), .has_data(has_data), .pkt_rcvd(pkt_rcvd),
      .credit_ret(credit_ret), .cont_phase(cont_phase), .data_phase(data_phase),
      .req_out(req_out), .cont_num(cont_num), .grant(grant));

   int errors = 0, checks = 0;
   bit done = 0;
   int unsigned rs = 32'h1234_5678;

   logic [3:0] lf[N];
   bit         pr[N];
   int         cr[N];
   int         cnt;
   logic [N-1:0] gm;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int unsigned rnd();
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      return rs;
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      has_data = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R8: reset state
      check("R8 grant", grant, 0);
      check("R8 cont_phase", cont_phase, 1);
      for (int i = 0; i < N; i++) begin
         check("R8 number", cont_num[i*K +: K], i + 1);
         check("R8 req", req_out[i], 1);
      end
      for (int i = 0; i < N; i++) begin lf[i] = 4'(i + 1); pr[i] = 0; cr[i] = CR; end
      cnt = 0; gm = '0;

      for (int cyc = 0; cyc < CYCLES; cyc++) begin
         int f;
         bit decide;
         logic [N-1:0] rq;
         logic [N-1:0] win;
         int best;
         if (cyc > 0) @(negedge clk);
         rst_n = 1'b1;
         f = cyc / FL;
         // stimulus
         if (f < 12) begin
            has_data = '1; pkt_rcvd = '0; credit_ret = '0;
         end else if (f >= 100 && f < 130) begin
            has_data = N'(1 << (f % N));
            pkt_rcvd = N'(rnd()) & N'(rnd());
            for (int i = 0; i < N; i++) credit_ret[i] = rnd()[0] && (cr[i] < CR);
         end else begin
            has_data = N'(rnd());
            pkt_rcvd = (f > 300) ? N'(rnd()) : (N'(rnd()) & N'(rnd()));
            for (int i = 0; i < N; i++) credit_ret[i] = rnd()[0] && rnd()[0] && (cr[i] < CR);
         end
         #1;
         // expected outputs from the model state
         check("R1 cont_phase", cont_phase, cnt < CL);
         check("R1 data_phase", data_phase, cnt >= CL);
         for (int i = 0; i < N; i++) begin
            rq[i] = (cnt < CL) && has_data[i] && (cr[i] > 0);
            check("R5 R7 number", cont_num[i*K +: K], {pr[i], lf[i]});
         end
         check("R2 R6 req_out", req_out, rq);
         check("R3 R4 grant", grant, gm);
         // model update for the coming edge
         decide = (cnt == CL - 1);
         win = '0; best = -1;
         for (int i = 0; i < N; i++)
            if (rq[i] && int'({pr[i], lf[i]}) > best) begin
               best = int'({pr[i], lf[i]}); win = '0; win[i] = 1'b1;
            end
         if (decide)            gm = win;
         else if (cnt == FL - 1) gm = '0;
         for (int i = 0; i < N; i++) begin
            if (decide && win[i]) cr[i]--;
            if (credit_ret[i])    cr[i]++;
            if (pkt_rcvd[i])      pr[i] = 1;
            else if (decide)      pr[i] = 0;
            if (decide)           lf[i] = {lf[i][2:0], lf[i][3] ^ lf[i][2]};
         end
         cnt = (cnt == FL - 1) ? 0 : cnt + 1;
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule